// File: doc/BRIEF.md
# Timer Compare Channel with Event Trigger

This block watches a free-running 16-bit timer that lives outside it and compares the timer, on every clock, with a 16-bit compare value held in a register. When the two become equal, a 4-bit mode field decides what happens. The output latch can be set high or cleared low. The channel can instead raise only its interrupt flag and leave the pin alone. In trigger mode it pulses a timer reset, so the compare value becomes the timer's period, and it can also request a conversion from an external converter.

Software reaches the block through a small write port. Address 0 loads the compare value. Address 1 loads the mode field from the low 4 bits of the data. Address 2 clears the interrupt flag, and address 3 is ignored. The block drives the pin only while the tristate input is low. The timer reset and converter start outputs are combinational, so an external timer can load zero on the same edge at which the match is seen. Every match sets the channel flag. The block has no overflow flag output, so a trigger never raises the timer's overflow flag.

Top module: `tcmp_channel`

## Requirements
- R1: A match needs all 16 bits of `timer_val` to equal the compare register. A value that differs only in the upper byte gives no event.
- R2: An event occurs only in the first cycle of equality. A timer that stays at the compare value gives exactly one event.
- R3: In mode 4'b1000, a match sets `pin_out` high at the clock edge where the match is seen.
- R4: In mode 4'b1001, a match clears `pin_out` low at that edge.
- R5: In mode 4'b1010, a match leaves `pin_out` unchanged.
- R6: Each match event in modes 1000 to 1011 sets `irq_flag` at that edge. The flag stays set until a write to address 2 clears it. A match in the same cycle as a clear wins.
- R7: In mode 4'b1011, `timer_rst` is high during the cycle in which the match is seen. It is low at every other time, and `pin_out` is unchanged.
- R8: `conv_start` rises together with `timer_rst`, but only when `conv_en` is high and the variant parameter `HAS_CONV` is 1.
- R9: Writing 4'b0000 to the mode field forces `pin_out` low at that edge.
- R10: `pin_oe` is the inverse of `tris`. `pin_out` always shows the output latch.
- R11: In mode 0000, and in any mode code not listed above, equality gives no event and does not set the flag.
- R12: After reset, the compare value, the mode, `pin_out` and `irq_flag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 compare, 1 mode, 2 flag clear, 3 ignored |
| wr_data | input | 16 | Write data |
| timer_val | input | 16 | Current timer value |
| conv_en | input | 1 | External converter is enabled |
| tris | input | 1 | Tristate bit, pin driven when low |
| timer_rst | output | 1 | Timer reset request (trigger mode) |
| conv_start | output | 1 | Converter start request |
| irq_flag | output | 1 | Sticky channel interrupt flag |
| pin_out | output | 1 | Output latch value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The assertions take the timer value and the compare register as ordinary synchronous inputs that are stable around the clock edge. The second-event check assumes that both hold steady across the cycle that follows a match. The stimulus changes the timer, the write port and `conv_en` only at falling edges. It steps the timer away from the compare value before each match it wants, so that every event it expects comes from a fresh rising edge of equality.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;
  localparam logic [3:0] MODE_OFF  = 4'b0000;
  localparam logic [3:0] MODE_SET  = 4'b1000;
  localparam logic [3:0] MODE_CLR  = 4'b1001;
  localparam logic [3:0] MODE_SOFT = 4'b1010;
  localparam logic [3:0] MODE_TRIG = 4'b1011;

  typedef enum logic [1:0] {
    ADDR_CMP  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_FCLR = 2'd2,
    ADDR_RSVD = 2'd3
  } waddr_e;
endpackage

// File: rtl/tcmp_regs.sv
module tcmp_regs
  import tcmp_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [TW-1:0] wr_data,
  output logic [TW-1:0] cmp_val,
  output logic [MW-1:0] mode,
  output logic          ctrl_zero_wr,
  output logic          flag_clr_wr
);
  logic unused_hi;
  assign unused_hi = ^wr_data[TW-1:MW];

  assign ctrl_zero_wr = wr_en && (wr_addr == ADDR_CTRL) && (wr_data[MW-1:0] == '0);
  assign flag_clr_wr  = wr_en && (wr_addr == ADDR_FCLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_val <= '0;
      mode    <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CMP)  cmp_val <= wr_data;
      if (wr_addr == ADDR_CTRL) mode    <= wr_data[MW-1:0];
    end
  end
endmodule

// File: rtl/tcmp_match.sv
module tcmp_match #(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic [TW-1:0] cmp_val,
  input  logic [MW-1:0] mode,
  output logic          match_ev
);
  logic eq, eq_q, active;

  assign eq     = (timer_val == cmp_val);
  // modes 10xx are the compare modes
  assign active = mode[MW-1] && !mode[MW-2];
  assign match_ev = active && eq && !eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end
endmodule

// File: rtl/tcmp_action.sv
module tcmp_action
  import tcmp_pkg::*;
#(
  parameter int MW       = 4,
  parameter bit HAS_CONV = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          match_ev,
  input  logic [MW-1:0] mode,
  input  logic          ctrl_zero_wr,
  input  logic          flag_clr_wr,
  input  logic          conv_en,
  output logic          latch_q,
  output logic          flag_q,
  output logic          timer_rst,
  output logic          conv_start
);
  assign timer_rst = match_ev && (mode == MODE_TRIG);

  generate
    if (HAS_CONV) begin : g_conv
      assign conv_start = timer_rst && conv_en;
    end else begin : g_noconv
      logic unused_conv;
      assign unused_conv = conv_en;
      assign conv_start  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (ctrl_zero_wr) begin
      latch_q <= 1'b0;
    end else if (match_ev) begin
      if (mode == MODE_SET)      latch_q <= 1'b1;
      else if (mode == MODE_CLR) latch_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (match_ev)   flag_q <= 1'b1;
    else if (flag_clr_wr) flag_q <= 1'b0;
  end
endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel #(
  parameter int TW       = 16,
  parameter int MW       = 4,
  parameter bit HAS_CONV = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [TW-1:0] wr_data,
  input  logic [TW-1:0] timer_val,
  input  logic          conv_en,
  input  logic          tris,
  output logic          timer_rst,
  output logic          conv_start,
  output logic          irq_flag,
  output logic          pin_out,
  output logic          pin_oe
);
  logic [TW-1:0] cmp_q;
  logic [MW-1:0] mode_q;
  logic          ctrl_zero_wr, flag_clr_wr, match_ev, latch_q;

  tcmp_regs #(.TW(TW), .MW(MW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_val(cmp_q), .mode(mode_q),
    .ctrl_zero_wr(ctrl_zero_wr), .flag_clr_wr(flag_clr_wr)
  );

  tcmp_match #(.TW(TW), .MW(MW)) u_match (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cmp_val(cmp_q),
    .mode(mode_q), .match_ev(match_ev)
  );

  tcmp_action #(.MW(MW), .HAS_CONV(HAS_CONV)) u_action (
    .clk(clk), .rst_n(rst_n), .match_ev(match_ev), .mode(mode_q),
    .ctrl_zero_wr(ctrl_zero_wr), .flag_clr_wr(flag_clr_wr),
    .conv_en(conv_en), .latch_q(latch_q), .flag_q(irq_flag),
    .timer_rst(timer_rst), .conv_start(conv_start)
  );

  assign pin_out = latch_q;
  assign pin_oe  = !tris;
endmodule

// File: rtl/tcmp_channel_chk.sv
module tcmp_channel_chk
  import tcmp_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          match_ev,
  input logic [MW-1:0] mode,
  input logic [TW-1:0] cmp_val,
  input logic [TW-1:0] timer_val,
  input logic          ctrl_zero_wr,
  input logic          conv_en,
  input logic          timer_rst,
  input logic          conv_start,
  input logic          irq_flag,
  input logic          pin_out
);
  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> irq_flag);
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(match_ev));
  assert_single_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> !(match_ev && $stable(timer_val) && $stable(cmp_val)));
  assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode == MODE_SET && !ctrl_zero_wr) |=> pin_out);
  assert_clear_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode == MODE_CLR) |=> !pin_out);
  assert_soft_keeps_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && mode == MODE_SOFT && !ctrl_zero_wr) |=> $stable(pin_out));
  assert_trig_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rst |-> (match_ev && mode == MODE_TRIG));
  assert_conv_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (timer_rst && conv_en));
  assert_zero_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_zero_wr |=> !pin_out);
endmodule

bind tcmp_channel tcmp_channel_chk #(.TW(TW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_ev(match_ev), .mode(mode_q),
  .cmp_val(cmp_q), .timer_val(timer_val), .ctrl_zero_wr(ctrl_zero_wr),
  .conv_en(conv_en), .timer_rst(timer_rst), .conv_start(conv_start),
  .irq_flag(irq_flag), .pin_out(pin_out)
);

// File: tb/tcmp_channel_test.sv
`timescale 1ns/1ps
module tcmp_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] timer_val = 16'hFFFF;
  logic        conv_en = 1'b0;
  logic        tris = 1'b1;
  logic        timer_rst, conv_start, irq_flag, pin_out, pin_oe;
  logic        s_trst, s_conv;
  int          total = 0;
  int          bad = 0;
  logic [15:0] cmp_cur = 16'd0;

  always #2.5 clk = ~clk;

  tcmp_channel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .timer_val(timer_val), .conv_en(conv_en),
    .tris(tris), .timer_rst(timer_rst), .conv_start(conv_start),
    .irq_flag(irq_flag), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
    if (a == 2'd0) cmp_cur = d;
  endtask

  // step away from the compare value, then land on it; comb outputs sampled
  task automatic fire();
    timer_val = cmp_cur - 16'd1;
    step();
    timer_val = cmp_cur;
    #1;
    s_trst = timer_rst;
    s_conv = conv_start;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 pin_out", pin_out, 0);
    check("R12 irq_flag", irq_flag, 0);
    check("R12 timer_rst", timer_rst, 0);
    wr(2'd1, 16'h000B);   // trigger mode with reset compare value 0
    fire();
    check("R12 compare reset to 0", s_trst, 1);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_full_width_and_set();
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h0008);
    timer_val = 16'h0000; step();
    timer_val = 16'h0234; step();
    check("R1 upper byte differs no flag", irq_flag, 0);
    check("R1 upper byte differs pin", pin_out, 0);
    fire();
    check("R3 set on match", pin_out, 1);
    check("R6 flag set", irq_flag, 1);
    check("R7 no timer_rst in set mode", s_trst, 0);
  endtask

  task automatic t_single_event();
    wr(2'd2, 16'h0000);
    check("R6 flag cleared by write", irq_flag, 0);
    step(); step();
    check("R2 held timer gives no second event", irq_flag, 0);
  endtask

  task automatic t_soft();
    wr(2'd1, 16'h000A);
    wr(2'd2, 16'h0000);
    fire();
    check("R5 pin unchanged high", pin_out, 1);
    check("R5 flag set", irq_flag, 1);
  endtask

  task automatic t_clear();
    wr(2'd1, 16'h0009);
    fire();
    check("R4 clear on match", pin_out, 0);
  endtask

  task automatic t_zero();
    wr(2'd1, 16'h0008);
    fire();
    check("R9 precondition high", pin_out, 1);
    wr(2'd1, 16'h0000);
    check("R9 zero write forces low", pin_out, 0);
    wr(2'd2, 16'h0000);
    fire();
    check("R11 off mode no flag", irq_flag, 0);
    wr(2'd1, 16'h000C);
    fire();
    check("R11 unlisted code no flag", irq_flag, 0);
    check("R11 unlisted code pin", pin_out, 0);
  endtask

  task automatic t_trigger();
    wr(2'd1, 16'h0008);
    fire();
    wr(2'd1, 16'h000B);
    wr(2'd2, 16'h0000);
    conv_en = 1'b1;
    fire();
    check("R7 timer_rst in match cycle", s_trst, 1);
    check("R8 conv_start when enabled", s_conv, 1);
    check("R7 timer_rst is a pulse", timer_rst, 0);
    check("R7 pin unchanged", pin_out, 1);
    check("R6 flag on trigger", irq_flag, 1);
    conv_en = 1'b0;
    wr(2'd2, 16'h0000);
    timer_val = cmp_cur - 16'd1;
    step();
    wr_en = 1'b1; wr_addr = 2'd2; timer_val = cmp_cur;   // clear and match together
    #1;
    s_trst = timer_rst; s_conv = conv_start;
    step();
    wr_en = 1'b0;
    check("R8 conv_start gated off", s_conv, 0);
    check("R7 timer_rst without converter", s_trst, 1);
    check("R6 match beats clear", irq_flag, 1);
  endtask

  task automatic t_oe();
    tris = 1'b1; #1;
    check("R10 tristated", pin_oe, 0);
    tris = 1'b0; #1;
    check("R10 driven", pin_oe, 1);
    check("R10 pin shows latch", pin_out, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_full_width_and_set();
        t_single_event();
        t_soft();
        t_clear();
        t_zero();
        t_trigger();
        t_oe();
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule